// File: doc/BRIEF.md
# SPI burst exchange engine

This block runs a byte-by-byte SPI exchange between a transmit queue and a receive queue. Software fills the transmit queue, sets the exchange request, and the engine takes over. For each transfer it pulls one byte from the transmit queue, shifts it out while the matching byte is shifted in, and then either stores the returned byte in the receive queue or drops it. The shifter uses SPI mode 0: the clock idles low, the most significant bit goes first, input is sampled on the rising edge and output changes after the falling edge. The serial clock comes from the system clock through a fixed even divider.

An exchange ends at the first of two limits. One is a programmable burst length, where zero means no limit. The other is the transmit queue running empty. An optional discard mode drops the received bytes of the first N transfers, with N taken from a programmable dummy count. This is used for command and address phases whose returned bytes carry no data. After every transfer, and when the exchange ends, the engine sends single-cycle event pulses to a separate interrupt unit.

Top module: `spi_burst_xchg`

## Requirements
- R1: After a synchronous reset, `xch_busy`, `sclk`, all event pulses, `tx_level` and `rx_level` are 0.
- R2: A `tx_push` while `tx_level` equals FIFO_DEPTH is ignored. The level does not change and the byte is never transmitted.
- R3: A `xch_start` pulse while idle captures `burst_len`, `dummy_len` and `discard_en` and raises `xch_busy` on the next cycle. A `xch_start` while busy has no effect on the running exchange.
- R4: Each transfer sends one byte MSB first in SPI mode 0. `sclk` idles low and has a period of SCLK_DIV system clocks. `mosi` changes only while `sclk` is low. `miso` is sampled on the rising edges. A transfer starts only after the previous byte has been fully received.
- R5: With a non-zero burst length B, the exchange ends after B transfers even if the transmit queue still holds bytes. Those bytes stay queued.
- R6: The exchange ends when the transmit queue is empty at the point where the next transfer would start, including at the very start. A burst length of 0 places no limit on the count.
- R7: The end of an exchange gives exactly one `ev_done` pulse in the same cycle that `xch_busy` falls. This holds even when the burst limit and the empty queue are reached on the same transfer.
- R8: With `discard_en` set, the received bytes of the first N transfers (N = `dummy_len`) are not stored. With `discard_en` clear, every received byte is kept.
- R9: A kept received byte that arrives while `rx_level` equals FIFO_DEPTH is not stored. `ev_rx_drop` pulses and the queue contents are unchanged.
- R10: `ev_byte` pulses once per completed transfer. `rx_pop` presents the oldest stored byte on `rx_data` one cycle later, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 8 | Byte to queue for transmission |
| tx_level | output | $clog2(FIFO_DEPTH+1) | Bytes in the transmit queue |
| rx_pop | input | 1 | Remove the oldest received byte |
| rx_data | output | 8 | Byte popped on the previous cycle |
| rx_level | output | $clog2(FIFO_DEPTH+1) | Bytes in the receive queue |
| xch_start | input | 1 | Exchange request pulse |
| discard_en | input | 1 | Drop the leading received bytes |
| burst_len | input | CNT_W | Transfer limit, 0 means none |
| dummy_len | input | CNT_W | Number of leading received bytes to drop |
| xch_busy | output | 1 | Exchange in progress |
| ev_byte | output | 1 | Pulse per completed transfer |
| ev_rx_drop | output | 1 | Pulse when a kept byte found the receive queue full |
| ev_done | output | 1 | Pulse at the end of an exchange |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two end conditions can fall on the same transfer: the burst count runs out exactly as the transmit queue drains. The bench provokes this by queuing three bytes and asking for a burst of three. It then counts the `ev_done` pulses over the following cycles and expects exactly one, with `xch_busy` low in that cycle. A second overlap comes from running transfers into a full receive queue. There the drop event and the final done pulse belong to the same last transfer, and the bench judges it by the drop count, the unchanged receive level and the order of the bytes popped afterwards.

// File: rtl/spi_bx_pkg.sv
package spi_bx_pkg;
  typedef enum logic [1:0] {
    XS_IDLE,
    XS_CHECK,
    XS_LAUNCH,
    XS_RUN
  } xs_state_e;

  typedef struct packed {
    logic byte_done;
    logic dropped;
    logic finish;
  } xs_event_t;
endpackage

// File: rtl/spi_bx_fifo.sv
module spi_bx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (level != LW'(DEPTH));
  assign pop_ok  = pop && (level != '0);

  // storage: no reset so a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
    if (pop_ok)  pop_data  <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_bx_shifter.sv
module spi_bx_shifter #(
  parameter int SCLK_DIV = 4,
  localparam int HALF    = SCLK_DIV / 2,
  localparam int TW      = $clog2(HALF + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  logic          active;
  logic [TW-1:0] tcnt;
  logic [2:0]    bitn;
  logic [6:0]    sreg;
  logic [7:0]    rreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      tcnt    <= '0;
      bitn    <= '0;
      sreg    <= '0;
      rreg    <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          tcnt   <= '0;
          bitn   <= '0;
          sclk   <= 1'b0;
          mosi   <= tx_byte[7];
          sreg   <= tx_byte[6:0];
        end
      end else if (tcnt == TW'(HALF - 1)) begin
        tcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rreg <= {rreg[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active  <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rreg;
          end else begin
            bitn <= bitn + 1'b1;
            mosi <= sreg[6];
            sreg <= {sreg[5:0], 1'b0};
          end
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_bx_seq.sv
module spi_bx_seq
  import spi_bx_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xch_start,
  input  logic             discard_en,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] dummy_len,
  input  logic             tx_empty,
  input  logic             rx_full,
  input  logic             sh_done,
  output logic             tx_pop,
  output logic             sh_start,
  output logic             rx_push,
  output logic             busy,
  output xs_event_t        ev
);
  xs_state_e        st;
  logic [CNT_W-1:0] bcnt, dcnt;
  logic             disc_q;
  logic             keep;

  always_comb begin
    keep     = !(disc_q && (dcnt != '0));
    tx_pop   = (st == XS_CHECK) && !tx_empty;
    sh_start = (st == XS_LAUNCH);
    rx_push  = (st == XS_RUN) && sh_done && keep && !rx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= XS_IDLE;
      busy   <= 1'b0;
      bcnt   <= '0;
      dcnt   <= '0;
      disc_q <= 1'b0;
      ev     <= '0;
    end else begin
      ev <= '0;
      case (st)
        XS_IDLE: begin
          if (xch_start) begin
            bcnt   <= burst_len;
            dcnt   <= dummy_len;
            disc_q <= discard_en;
            busy   <= 1'b1;
            st     <= XS_CHECK;
          end
        end
        XS_CHECK: begin
          if (tx_empty) begin
            busy      <= 1'b0;
            ev.finish <= 1'b1;
            st        <= XS_IDLE;
          end else begin
            st <= XS_LAUNCH;
          end
        end
        XS_LAUNCH: st <= XS_RUN;
        XS_RUN: begin
          if (sh_done) begin
            ev.byte_done <= 1'b1;
            if (!keep)        dcnt       <= dcnt - 1'b1;
            else if (rx_full) ev.dropped <= 1'b1;
            if (bcnt == CNT_W'(1)) begin
              busy      <= 1'b0;
              ev.finish <= 1'b1;
              st        <= XS_IDLE;
            end else begin
              if (bcnt != '0) bcnt <= bcnt - 1'b1;
              st <= XS_CHECK;
            end
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_xchg.sv
module spi_burst_xchg
  import spi_bx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 24,
  parameter int SCLK_DIV   = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_push,
  input  logic [7:0]       tx_data,
  output logic [LVL_W-1:0] tx_level,
  input  logic             rx_pop,
  output logic [7:0]       rx_data,
  output logic [LVL_W-1:0] rx_level,
  input  logic             xch_start,
  input  logic             discard_en,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [CNT_W-1:0] dummy_len,
  output logic             xch_busy,
  output logic             ev_byte,
  output logic             ev_rx_drop,
  output logic             ev_done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic       tx_pop, sh_start, sh_done, rx_push;
  logic [7:0] tx_head, sh_rx;
  logic       tx_empty, rx_full;
  xs_event_t  ev;

  assign tx_empty   = (tx_level == '0);
  assign rx_full    = (rx_level == LVL_W'(FIFO_DEPTH));
  assign ev_byte    = ev.byte_done;
  assign ev_rx_drop = ev.dropped;
  assign ev_done    = ev.finish;

  spi_bx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(tx_push), .push_data(tx_data),
    .pop(tx_pop), .pop_data(tx_head),
    .level(tx_level)
  );

  spi_bx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_push), .push_data(sh_rx),
    .pop(rx_pop), .pop_data(rx_data),
    .level(rx_level)
  );

  spi_bx_shifter #(.SCLK_DIV(SCLK_DIV)) u_shift (
    .clk(clk), .rst(rst),
    .start(sh_start), .tx_byte(tx_head), .miso(miso),
    .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_byte(sh_rx)
  );

  spi_bx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst),
    .xch_start(xch_start), .discard_en(discard_en),
    .burst_len(burst_len), .dummy_len(dummy_len),
    .tx_empty(tx_empty), .rx_full(rx_full), .sh_done(sh_done),
    .tx_pop(tx_pop), .sh_start(sh_start), .rx_push(rx_push),
    .busy(xch_busy), .ev(ev)
  );
endmodule

// File: rtl/spi_bx_checker.sv
module spi_bx_checker #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          xch_start,
  input logic          xch_busy,
  input logic          ev_done,
  input logic          ev_rx_drop,
  input logic          sclk,
  input logic          mosi,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);
  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R2

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (xch_start && !xch_busy) |=> xch_busy); // R3

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R4

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !xch_busy |-> !sclk); // R4

  AST_DONE_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
    ev_done |-> (!xch_busy && $past(xch_busy))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> !ev_done); // R7

  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    ev_rx_drop |-> ($past(rx_level) == LW'(DEPTH))); // R9
endmodule

bind spi_burst_xchg spi_bx_checker #(.DEPTH(FIFO_DEPTH), .LW(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .xch_start(xch_start), .xch_busy(xch_busy),
  .ev_done(ev_done), .ev_rx_drop(ev_rx_drop), .sclk(sclk), .mosi(mosi),
  .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spi_burst_xchg_bench.sv
module spi_burst_xchg_bench;
  localparam int DEPTH = 8;
  localparam int CW    = 24;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tx_push = 1'b0, rx_pop = 1'b0, xch_start = 1'b0, discard_en = 1'b0;
  logic [7:0]    tx_data = '0;
  logic [CW-1:0] burst_len = '0, dummy_len = '0;
  logic          miso = 1'b0;
  logic [LW-1:0] tx_level, rx_level;
  logic [7:0]    rx_data;
  logic          xch_busy, ev_byte, ev_rx_drop, ev_done, sclk, mosi;

  int n_tests = 0, n_fail = 0;
  int cnt_done = 0, cnt_byte = 0, cnt_drop = 0;
  int txm = 0, rxm = 0, bk = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  always #10 clk = ~clk;

  spi_burst_xchg #(.FIFO_DEPTH(DEPTH), .CNT_W(CW), .SCLK_DIV(4)) u_spi_burst_xchg (
    .clk(clk), .rst(rst), .tx_push(tx_push), .tx_data(tx_data), .tx_level(tx_level),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_level(rx_level),
    .xch_start(xch_start), .discard_en(discard_en), .burst_len(burst_len),
    .dummy_len(dummy_len), .xch_busy(xch_busy), .ev_byte(ev_byte),
    .ev_rx_drop(ev_rx_drop), .ev_done(ev_done), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic [7:0] resp(int k);
    return 8'(8'h5A + 29 * k);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // event counters, sampled mid-cycle
  initial forever begin
    @(negedge clk);
    if (ev_done)    cnt_done++;
    if (ev_byte)    cnt_byte++;
    if (ev_rx_drop) cnt_drop++;
  end

  // slave: presents response bytes MSB first, changing after falling edges
  initial begin
    int k = 0;
    forever begin
      logic [7:0] m;
      m = resp(k);
      miso = m[7];
      for (int i = 0; i < 8; i++) begin
        @(negedge sclk);
        if (i < 7) miso = m[6 - i];
      end
      k++;
    end
  end

  // monitor: captures mosi on rising edges, compares with scoreboard (R4)
  initial begin
    logic [7:0] sh = '0;
    int nb = 0;
    forever begin
      @(posedge sclk);
      sh = {sh[6:0], mosi};
      nb++;
      if (nb == 8) begin
        nb = 0;
        if (exp_tx.size() == 0) chk("R4 unexpected byte", int'(sh), -1);
        else chk("R4 mosi byte", int'(sh), int'(exp_tx.pop_front()));
      end
    end
  end

  task automatic push_tx(logic [7:0] b);
    @(negedge clk);
    tx_push = 1'b1;
    tx_data = b;
    if (txm < DEPTH) begin
      exp_tx.push_back(b);
      txm++;
    end
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic run_xch(int burst, bit disc, int dummy, bit poke, string tag);
    int n, drops, waited;
    n = (burst == 0 || burst > txm) ? txm : burst;
    drops = 0;
    for (int i = 0; i < n; i++) begin
      if (!(disc && i < dummy)) begin
        if (rxm < DEPTH) begin
          exp_rx.push_back(resp(bk));
          rxm++;
        end else drops++;
      end
      bk++;
    end
    txm -= n;
    cnt_done = 0; cnt_byte = 0; cnt_drop = 0;
    @(negedge clk);
    xch_start  = 1'b1;
    burst_len  = CW'(burst);
    dummy_len  = CW'(dummy);
    discard_en = disc;
    @(negedge clk);
    xch_start = 1'b0;
    chk("R3 busy after start", int'(xch_busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      xch_start = 1'b1;
      burst_len = CW'(1);
      @(negedge clk);
      xch_start = 1'b0;
    end
    waited = 0;
    while (cnt_done == 0 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk("R7 busy low at done", int'(xch_busy), 0);
    repeat (4) @(negedge clk);
    chk("R7 one done pulse", cnt_done, 1);
    chk({tag, " transfer count"}, cnt_byte, n);
    chk({tag, " tx left"}, int'(tx_level), txm);
    chk("R9 drop pulses", cnt_drop, drops);
    chk("R8 rx level", int'(rx_level), rxm);
  endtask

  task automatic pop_rx(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
      if (exp_rx.size() == 0) chk("R10 rx empty model", int'(rx_data), -1);
      else chk("R10 rx byte", int'(rx_data), int'(exp_rx.pop_front()));
      rxm--;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(xch_busy), 0);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 tx level", int'(tx_level), 0);
    chk("R1 rx level", int'(rx_level), 0);
    chk("R1 done", int'(ev_done), 0);

    // empty queue at start
    run_xch(0, 0, 0, 0, "R6");

    // unbounded, ends on empty queue
    push_tx(8'h81); push_tx(8'h42); push_tx(8'hC3);
    run_xch(0, 0, 0, 0, "R6");
    pop_rx(3);

    // burst limit before queue empties
    for (int i = 0; i < 5; i++) push_tx(8'(8'h10 + 8'(i) * 8'h21));
    run_xch(2, 0, 0, 0, "R5");
    chk("R5 leftover", int'(tx_level), 3);
    pop_rx(2);
    run_xch(0, 0, 0, 0, "R6");
    pop_rx(3);

    // burst limit and empty queue on the same transfer
    push_tx(8'hF0); push_tx(8'h0F); push_tx(8'hAA);
    run_xch(3, 0, 0, 0, "R7");
    pop_rx(3);

    // discard leading bytes
    for (int i = 0; i < 4; i++) push_tx(8'(8'h33 + 8'(i)));
    run_xch(0, 1, 2, 0, "R8");
    pop_rx(2);
    // dummy count ignored without discard
    push_tx(8'h01); push_tx(8'h80); push_tx(8'h7E);
    run_xch(0, 0, 3, 0, "R8");
    pop_rx(3);
    // dummy count larger than the exchange
    push_tx(8'h55); push_tx(8'h66);
    run_xch(0, 1, 5, 0, "R8");

    // receive queue overflow
    for (int i = 0; i < 8; i++) push_tx(8'(8'hA0 + 8'(i)));
    run_xch(0, 0, 0, 0, "R6");
    push_tx(8'hE1); push_tx(8'hE2);
    run_xch(0, 0, 0, 0, "R9");
    chk("R9 rx stays full", int'(rx_level), DEPTH);
    pop_rx(8);

    // push into full transmit queue, start while busy
    for (int i = 0; i < 10; i++) push_tx(8'(8'hC0 + 8'(i)));
    chk("R2 tx level capped", int'(tx_level), DEPTH);
    run_xch(0, 0, 0, 1, "R3");
    pop_rx(8);
    chk("R2 tx queue empty", exp_tx.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule